// File: doc/BRIEF.md
# Three-Wire Divider-Ratio Loader

This block receives divider settings for a frequency synthesizer over three slow wires: a serial data line, a serial clock and a load strobe. All three wires are brought into the system clock domain through flop chains. Each rising edge of the synchronised serial clock pushes one data bit into a 19-bit shift register. Words are sent most significant bit first, and the control bit is always the last bit sent.

On a rising edge of the synchronised load strobe, the control bit at position 0 picks the destination. A high control bit selects the reference register: a 14-bit reference ratio, a prescaler-modulus select bit and a power-enable bit. A low control bit selects the divider register: a 7-bit swallow count and an 11-bit main count. Each register gives a one-cycle update pulse when it takes new values. A word whose ratio lies below the legal floor is refused. The register then keeps its old contents and gives a reject pulse instead.

Top module: `serial_ratio_loader`

## Requirements
- R1: One data bit enters the shift register for each rising edge of the serial clock. The newest bit goes in at position 0 and older bits move one place up. Holding the serial clock high, or changing data while it is high, adds no bits.
- R2: When the load strobe rises and position 0 is 1, the reference register loads its fields. `ref_ratio` takes positions 14..1, `presc_small` takes position 15 and `pwr_on` takes position 16. Positions 18..17 have no effect.
- R3: When the load strobe rises and position 0 is 0, the divider register loads its fields. `swallow` takes positions 7..1 and `main_count` takes positions 18..8.
- R4: `ref_upd` and `div_upd` are each high for exactly one cycle. That cycle is the first cycle in which the new field values are visible.
- R5: A reference word with a ratio below 6 is refused. The ratio, `presc_small` and `pwr_on` all keep their old values, `ref_reject` pulses for one cycle and `ref_upd` stays low. A ratio of 6 or of 16383 is accepted.
- R6: A divider word with a main count below 5 is refused. Both divider fields keep their old values, `div_reject` pulses for one cycle and `div_upd` stays low. A main count of 5 with a swallow count of 0 is accepted, and so is a main count of 2047 with a swallow count of 127.
- R7: A load into either register leaves the other register unchanged. The two update pulses are never high together.
- R8: While reset is high, and on the first cycle after it, every output is 0.
- R9: A load strobe held high for many cycles causes exactly one load.
- R10: The fields and the update pulse change on the third rising edge of `clk` at which the load strobe is sampled high at the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_le | input | 1 | Load strobe, asynchronous |
| ref_ratio | output | 14 | Reference divide ratio |
| presc_small | output | 1 | 1 selects the smaller prescaler modulus |
| pwr_on | output | 1 | 1 means normal operation, 0 means standby |
| swallow | output | 7 | Swallow count |
| main_count | output | 11 | Main counter value |
| ref_upd | output | 1 | Reference register loaded |
| div_upd | output | 1 | Divider register loaded |
| ref_reject | output | 1 | Reference word refused |
| div_reject | output | 1 | Divider word refused |

## Verification
The hardest case to reach from the ports is a serial clock that stays high for a long time while the data line changes underneath it. This exposes a design that shifts on the level of the clock rather than on its edge. The stimulus sends 18 bits of a divider word normally. It then raises the serial clock for the last bit, holds it high for dozens of system cycles and toggles the data during that time. Only the final loaded values show whether exactly one bit was taken. A long load strobe is covered the same way, by counting update pulses over the whole time the strobe is high.

// File: rtl/sl_pkg.sv
package sl_pkg;
    localparam int REF_W      = 14;
    localparam int SWL_W      = 7;
    localparam int MAIN_W     = 11;
    localparam int SR_W       = 1 + SWL_W + MAIN_W;
    localparam int REF_WORD_W = 1 + REF_W + 2;
    localparam int REF_MIN    = 6;
    localparam int MAIN_MIN   = 5;
    localparam int SYNC_N     = 2;

    typedef enum logic {
        DEST_DIV = 1'b0,
        DEST_REF = 1'b1
    } dest_e;

    typedef struct packed {
        logic             pwr_on;
        logic             small_mod;
        logic [REF_W-1:0] ratio;
    } ref_cfg_t;

    typedef struct packed {
        logic [MAIN_W-1:0] main;
        logic [SWL_W-1:0]  swallow;
    } div_cfg_t;

    function automatic logic ref_legal(input ref_cfg_t c);
        return c.ratio >= REF_W'(REF_MIN);
    endfunction

    function automatic logic div_legal(input div_cfg_t c);
        return c.main >= MAIN_W'(MAIN_MIN);
    endfunction
endpackage

// File: rtl/sl_sync.sv
module sl_sync #(
    parameter int STAGES = 2,
    parameter bit EDGE   = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic q
);
    logic [STAGES-1:0] tap;

    always_ff @(posedge clk) begin
        if (rst) tap <= '0;
        else     tap <= {tap[STAGES-2:0], din};
    end

    generate
        if (EDGE) begin : g_edge
            logic prev;
            always_ff @(posedge clk) begin
                if (rst) prev <= 1'b0;
                else     prev <= tap[STAGES-1];
            end
            assign q = tap[STAGES-1] & ~prev;

            // R9: an edge pulse never lasts two cycles
            assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
                q |=> !q);
        end else begin : g_level
            assign q = tap[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sl_shifter.sv
module sl_shifter #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (shift) q <= {q[W-2:0], bit_in};
    end

    // R1: without a clock edge the register holds
    assert_hold_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !shift |=> $stable(q));
endmodule

// File: rtl/sl_ref_latch.sv
module sl_ref_latch
    import sl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  ref_cfg_t cand,
    output ref_cfg_t cfg,
    output logic     upd,
    output logic     reject
);
    logic legal;
    assign legal = ref_legal(cand);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            upd    <= 1'b0;
            reject <= 1'b0;
        end else begin
            upd    <= load & legal;
            reject <= load & ~legal;
            if (load && legal) cfg <= cand;
        end
    end

    assert_ratio_floor_R5: assert property (@(posedge clk) disable iff (rst)
        upd |-> cfg.ratio >= REF_W'(REF_MIN));
    assert_reject_holds_R5: assert property (@(posedge clk) disable iff (rst)
        reject |-> $stable(cfg));
    assert_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        upd |=> !upd);
endmodule

// File: rtl/sl_div_latch.sv
module sl_div_latch
    import sl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  div_cfg_t cand,
    output div_cfg_t cfg,
    output logic     upd,
    output logic     reject
);
    logic legal;
    assign legal = div_legal(cand);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            upd    <= 1'b0;
            reject <= 1'b0;
        end else begin
            upd    <= load & legal;
            reject <= load & ~legal;
            if (load && legal) cfg <= cand;
        end
    end

    assert_main_floor_R6: assert property (@(posedge clk) disable iff (rst)
        upd |-> cfg.main >= MAIN_W'(MAIN_MIN));
    assert_reject_holds_R6: assert property (@(posedge clk) disable iff (rst)
        reject |-> $stable(cfg));
endmodule

// File: rtl/serial_ratio_loader.sv
module serial_ratio_loader
    import sl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    output logic [REF_W-1:0]  ref_ratio,
    output logic              presc_small,
    output logic              pwr_on,
    output logic [SWL_W-1:0]  swallow,
    output logic [MAIN_W-1:0] main_count,
    output logic              ref_upd,
    output logic              div_upd,
    output logic              ref_reject,
    output logic              div_reject
);
    localparam int NIN = 3;
    localparam bit [NIN-1:0] EDGE_SEL = 3'b101;

    logic [NIN-1:0] raw, syn;
    assign raw = {ser_le, ser_data, ser_clk};

    genvar g;
    generate
        for (g = 0; g < NIN; g++) begin : g_sync
            sl_sync #(.STAGES(SYNC_N), .EDGE(EDGE_SEL[g])) u_sync (
                .clk (clk),
                .rst (rst),
                .din (raw[g]),
                .q   (syn[g])
            );
        end
    endgenerate

    logic            clk_rise, data_s, le_rise;
    logic [SR_W-1:0] sr;
    dest_e           dest;

    assign clk_rise = syn[0];
    assign data_s   = syn[1];
    assign le_rise  = syn[2];

    sl_shifter #(.W(SR_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .shift  (clk_rise),
        .bit_in (data_s),
        .q      (sr)
    );

    assign dest = dest_e'(sr[0]);

    ref_cfg_t ref_cfg;
    div_cfg_t div_cfg;

    sl_ref_latch u_ref (
        .clk    (clk),
        .rst    (rst),
        .load   (le_rise && dest == DEST_REF),
        .cand   (ref_cfg_t'(sr[REF_WORD_W-1:1])),
        .cfg    (ref_cfg),
        .upd    (ref_upd),
        .reject (ref_reject)
    );

    sl_div_latch u_div (
        .clk    (clk),
        .rst    (rst),
        .load   (le_rise && dest == DEST_DIV),
        .cand   (div_cfg_t'(sr[SR_W-1:1])),
        .cfg    (div_cfg),
        .upd    (div_upd),
        .reject (div_reject)
    );

    assign ref_ratio   = ref_cfg.ratio;
    assign presc_small = ref_cfg.small_mod;
    assign pwr_on      = ref_cfg.pwr_on;
    assign swallow     = div_cfg.swallow;
    assign main_count  = div_cfg.main;

    assert_one_dest_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ref_upd, div_upd, ref_reject, div_reject}));
    assert_div_untouched_R7: assert property (@(posedge clk) disable iff (rst)
        (ref_upd || ref_reject) |-> $stable(div_cfg));
    assert_ref_untouched_R7: assert property (@(posedge clk) disable iff (rst)
        (div_upd || div_reject) |-> $stable(ref_cfg));
endmodule

// File: tb/test_serial_ratio_loader.sv
module test_serial_ratio_loader;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [13:0] ref_ratio;
    logic        presc_small, pwr_on;
    logic [6:0]  swallow;
    logic [10:0] main_count;
    logic        ref_upd, div_upd, ref_reject, div_reject;

    always #2 clk = ~clk;

    serial_ratio_loader i_serial_ratio_loader (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .ref_ratio(ref_ratio), .presc_small(presc_small), .pwr_on(pwr_on),
        .swallow(swallow), .main_count(main_count),
        .ref_upd(ref_upd), .div_upd(div_upd),
        .ref_reject(ref_reject), .div_reject(div_reject)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: history of port samples, one word, two registers
    logic [2:0] hist[$];
    logic [2:0] now_s, old_s;
    logic [18:0] m_sr;
    int m_ratio, m_small, m_pwr, m_swl, m_main;
    int m_rupd, m_dupd, m_rrej, m_drej;

    always @(posedge clk) begin
        if (rst) begin
            hist = '{3'b0, 3'b0, 3'b0, 3'b0};
            m_sr = '0;
            m_ratio = 0; m_small = 0; m_pwr = 0; m_swl = 0; m_main = 0;
            m_rupd = 0; m_dupd = 0; m_rrej = 0; m_drej = 0;
        end else begin
            hist.push_front({ser_clk, ser_data, ser_le});
            void'(hist.pop_back());
            now_s = hist[2];
            old_s = hist[3];
            m_rupd = 0; m_dupd = 0; m_rrej = 0; m_drej = 0;
            if (now_s[0] && !old_s[0]) begin
                if (m_sr[0]) begin
                    if (int'(m_sr[14:1]) >= 6) begin
                        m_ratio = int'(m_sr[14:1]); m_small = int'(m_sr[15]);
                        m_pwr = int'(m_sr[16]); m_rupd = 1;
                    end else m_rrej = 1;
                end else begin
                    if (int'(m_sr[18:8]) >= 5) begin
                        m_swl = int'(m_sr[7:1]); m_main = int'(m_sr[18:8]); m_dupd = 1;
                    end else m_drej = 1;
                end
            end
            if (now_s[2] && !old_s[2]) m_sr = {m_sr[17:0], now_s[1]};
        end
    end

    int n_rupd = 0, n_dupd = 0, n_rrej = 0, n_drej = 0;

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R2 model ref_ratio", int'(ref_ratio), m_ratio);
            chk("R2 model presc_small", int'(presc_small), m_small);
            chk("R2 model pwr_on", int'(pwr_on), m_pwr);
            chk("R3 model swallow", int'(swallow), m_swl);
            chk("R3 model main_count", int'(main_count), m_main);
            chk("R4 model ref_upd", int'(ref_upd), m_rupd);
            chk("R4 model div_upd", int'(div_upd), m_dupd);
            chk("R5 model ref_reject", int'(ref_reject), m_rrej);
            chk("R6 model div_reject", int'(div_reject), m_drej);
            n_rupd += int'(ref_upd); n_dupd += int'(div_upd);
            n_rrej += int'(ref_reject); n_drej += int'(div_reject);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [18:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = w[i];
            tick(3);
            ser_clk = 1'b1;
            tick(3);
            ser_clk = 1'b0;
        end
        tick(2);
    endtask

    task automatic load();
        ser_le = 1'b1;
        tick(4);
        ser_le = 1'b0;
        tick(6);
    endtask

    function automatic logic [18:0] ref_word(input int r, input bit sm, input bit pw);
        return {2'b00, pw, sm, 14'(r), 1'b1};
    endfunction

    function automatic logic [18:0] div_word(input int a, input int n);
        return {11'(n), 7'(a), 1'b0};
    endfunction

    task automatic summary();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        int c0, c1;
        tick(5);
        // R8: outputs under reset
        chk("R8 reset ref_ratio", int'(ref_ratio), 0);
        chk("R8 reset main_count", int'(main_count), 0);
        chk("R8 reset strobes", int'({ref_upd, div_upd, ref_reject, div_reject}), 0);
        rst = 1'b0;
        tick(1);
        chk("R8 after reset pwr_on", int'(pwr_on), 0);

        // R1/R2: 19 bits with junk on top of a reference word
        send(ref_word(1000, 1'b1, 1'b1) | 19'h60000, 19);
        load();
        chk("R2 ratio", int'(ref_ratio), 1000);
        chk("R2 presc_small", int'(presc_small), 1);
        chk("R2 pwr_on", int'(pwr_on), 1);

        // R3/R10: divider word with exact latency
        send(div_word(100, 1234), 19);
        ser_le = 1'b1;
        tick(1);
        chk("R10 edge1 no update", int'(div_upd), 0);
        tick(1);
        chk("R10 edge2 no update", int'(main_count), 0);
        tick(1);
        chk("R10 edge3 div_upd", int'(div_upd), 1);
        chk("R3 main_count", int'(main_count), 1234);
        chk("R3 swallow", int'(swallow), 100);
        tick(1);
        chk("R4 div_upd one cycle", int'(div_upd), 0);
        ser_le = 1'b0;
        tick(6);
        chk("R7 ref kept", int'(ref_ratio), 1000);

        // R5: prohibited ratio
        c0 = n_rrej; c1 = n_rupd;
        send(ref_word(5, 1'b0, 1'b0), 17);
        load();
        chk("R5 reject pulse", n_rrej - c0, 1);
        chk("R5 no update", n_rupd - c1, 0);
        chk("R5 ratio kept", int'(ref_ratio), 1000);
        chk("R5 presc kept", int'(presc_small), 1);
        chk("R5 pwr kept", int'(pwr_on), 1);
        chk("R7 div kept", int'(main_count), 1234);

        send(ref_word(6, 1'b0, 1'b0), 17);
        load();
        chk("R5 floor accepted", int'(ref_ratio), 6);
        chk("R2 standby", int'(pwr_on), 0);
        send(ref_word(16383, 1'b1, 1'b0), 17);
        load();
        chk("R5 max accepted", int'(ref_ratio), 16383);

        // R6: prohibited main count and boundaries
        c0 = n_drej;
        send(div_word(3, 4), 19);
        load();
        chk("R6 reject pulse", n_drej - c0, 1);
        chk("R6 main kept", int'(main_count), 1234);
        chk("R6 swallow kept", int'(swallow), 100);
        send(div_word(0, 5), 19);
        load();
        chk("R6 floor main", int'(main_count), 5);
        chk("R6 zero swallow", int'(swallow), 0);
        send(div_word(127, 2047), 19);
        load();
        chk("R6 max main", int'(main_count), 2047);
        chk("R6 max swallow", int'(swallow), 127);

        // R9: long load strobe loads once
        c0 = n_rupd;
        send(ref_word(777, 1'b0, 1'b1), 17);
        ser_le = 1'b1;
        tick(40);
        ser_le = 1'b0;
        tick(6);
        chk("R9 single load", n_rupd - c0, 1);
        chk("R9 ratio", int'(ref_ratio), 777);

        // R1: serial clock held high while data toggles adds one bit only
        begin
            logic [18:0] w;
            w = div_word(50, 300);
            send(w >> 1, 18);
            ser_data = 1'b0;
            tick(3);
            ser_clk = 1'b1;
            tick(10);
            ser_data = 1'b1;
            tick(15);
            ser_data = 1'b0;
            tick(15);
            ser_clk = 1'b0;
            tick(4);
            load();
            chk("R1 main after held clock", int'(main_count), 300);
            chk("R1 swallow after held clock", int'(swallow), 50);
        end

        tick(5);
        summary();
    end
endmodule